// File: doc/BRIEF.md
# Streaming Byte-Opcode Decoder

This block turns a stream of instruction bytes into one decoded record per instruction. Bytes arrive one at a time over a valid/ready handshake, each tagged with its own address. The decoder breaks every opcode byte into five bit fields: a two-bit major group, a three-bit row, a three-bit column, a two-bit pair code and a one-bit pair modifier. It then works out how many more bytes the instruction needs, gathers them, and issues a single record. The record holds an operation class, register, pair, condition, function and bit-index selectors, the 16-bit immediate or sign-extended displacement, the length in bytes and the start address.

The decoder covers the unprefixed opcode page and the bit/rotate page that follows prefix 0xCB. Prefixes 0xDD, 0xED and 0xFD are not decoded. Each of them produces a one-byte record with the unsupported flag set, and decoding carries on with the next byte. The record stays in an output register until the consumer accepts it. While a record is waiting and the consumer is not ready, no new byte is taken.

Top module: `opdec_stream`

## Requirements
- R1: Each opcode byte splits into group g = bits 7:6, row r = bits 5:3 and column c = bits 2:0. 8-bit register codes 0..7 select B, C, D, E, H, L, memory at HL, A. In group 1, byte 0x76 is a halt and every other byte is a register copy with `out_dst` = r and `out_src` = c. A group-0, column-6 byte takes one unsigned immediate byte as an immediate load into register r. Group 0, column 0, rows 0 and 1 are one-byte no-operation and accumulator-swap records.
- R2: In group 0, column 0, rows 2 to 7 read one displacement byte. That byte is reported sign-extended to 16 bits with a length of 2. Rows 4 to 7 are conditional relative jumps with `out_cond` = r - 4.
- R3: A 16-bit immediate is assembled from the first following byte as the low half and the second as the high half, and the length is 3. Idle cycles between the bytes do not change the result, and no record appears before the last byte.
- R4: Group 2 (register operand) and group 3, column 6 (one unsigned immediate byte) report the ALU operation in `out_func` = r, ordered add, add-with-carry, subtract, subtract-with-borrow, and, xor, or, compare. Group 2 also reports the register in `out_src`.
- R5: Conditional return (g=3, c=0), conditional jump (c=2) and conditional call (c=4) report `out_cond` = r, with 0..7 meaning not-zero, zero, no-carry, carry, parity-odd, parity-even, plus, minus. The jump and the call carry a 16-bit address.
- R6: A restart byte (g=3, c=7) is one byte long, and its `out_imm` is r*8.
- R7: After prefix 0xCB, the second byte gives a length-2 record. g=0 is a shift/rotate with `out_func` = r. g=1, 2, 3 are bit test, bit clear and bit set, with `out_bit` = r. In all cases `out_src` = c.
- R8: Group 3, column 3 decodes as: row 0 absolute jump with a 16-bit address; row 2 port output and row 3 port input, each with one port byte; row 4 stack/HL swap; row 5 DE/HL swap; row 6 interrupt disable; row 7 interrupt enable.
- R9: `out_pair` = bits 5:4 selects BC, DE, HL, SP. For push and pop, code 3 means AF.
- R10: Bytes 0xDD, 0xED and 0xFD each yield a record with `out_unsup` = 1, class unsupported, length 1 and immediate 0. The next byte starts a new instruction.
- R11: `out_start` equals the address that came with the first byte of the instruction, including a prefix byte. Across address wrap, the next start equals start + length modulo 2^ADDR_W.
- R12: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and every record output holds steady.
- R13: After reset, `out_valid` = 0 and `in_ready` = 1. A partly collected instruction is dropped, and the next byte is decoded as a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Instruction byte |
| in_addr | input | ADDR_W | Address of this byte |
| in_ready | output | 1 | Byte accepted on this edge when in_valid is high |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_class | output | 6 | Operation class |
| out_dst | output | 3 | Destination register code |
| out_src | output | 3 | Source register code |
| out_pair | output | 2 | Register-pair code |
| out_cond | output | 3 | Condition code |
| out_func | output | 3 | ALU / shift / accumulator function |
| out_bit | output | 3 | Bit index |
| out_imm | output | 16 | Immediate, address, port or extended displacement |
| out_len | output | LEN_W | Instruction length in bytes |
| out_start | output | ADDR_W | Start address of the instruction |
| out_unsup | output | 1 | Prefix not supported |

## Verification
The bench builds the decoder with ADDR_W = 16 and LEN_W = 3. At these values every length from 1 to 3 is representable. The start-address chain can also run from 0xFFE0 across the wrap to 0x0000 within one vector walk. The walk mixes one-, two- and three-byte forms with both CB-page and unsupported prefixes. This shows that the length accounting keeps each following start address correct.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int unsigned IMM_W = 16;
    localparam int unsigned CLS_W = 6;

    typedef enum logic [CLS_W-1:0] {
        OP_NOP,      OP_SWAP_AF,  OP_DEC_JNZ,  OP_JREL,     OP_JREL_CC,
        OP_LD_PAIR_I, OP_ADD_HL,  OP_ST_A_PAIR, OP_LD_A_PAIR, OP_ST_HL_ABS,
        OP_LD_HL_ABS, OP_ST_A_ABS, OP_LD_A_ABS, OP_INC_PAIR, OP_DEC_PAIR,
        OP_INC_REG,  OP_DEC_REG,  OP_LD_REG_I, OP_ACC_OP,   OP_HALT,
        OP_LD_REG,   OP_ALU_REG,  OP_ALU_IMM,  OP_RET_CC,   OP_POP,
        OP_RET,      OP_SWAP_BANK, OP_JP_HL,   OP_LD_SP_HL, OP_JP_CC,
        OP_JP,       OP_PORT_OUT, OP_PORT_IN,  OP_SWAP_SPHL, OP_SWAP_DEHL,
        OP_INT_OFF,  OP_INT_ON,   OP_CALL_CC,  OP_PUSH,     OP_CALL,
        OP_RESTART,  OP_SHIFT,    OP_BIT_TEST, OP_BIT_CLR,  OP_BIT_SET,
        OP_UNSUP
    } op_class_e;

    typedef enum logic [1:0] {
        IMM_NONE,
        IMM_U8,
        IMM_S8,
        IMM_W16
    } imm_kind_e;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_CBOP,
        ST_IMM8,
        ST_IMM_LO,
        ST_IMM_HI
    } fsm_e;

    typedef struct packed {
        op_class_e        cls;
        logic [2:0]       dst;
        logic [2:0]       src;
        logic [1:0]       pair;
        logic [2:0]       cond;
        logic [2:0]       func;
        logic [2:0]       bit_idx;
        logic [IMM_W-1:0] imm;
        logic             unsup;
    } dec_fields_t;

    typedef struct packed {
        dec_fields_t f;
        imm_kind_e   kind;
        logic        cb_prefix;
    } main_dec_t;

endpackage

// File: rtl/opdec_split.sv
module opdec_split (
    input  logic [7:0] opc,
    output logic [1:0] grp,
    output logic [2:0] row,
    output logic [2:0] col,
    output logic [1:0] pcode,
    output logic       qbit
);
    assign grp   = opc[7:6];
    assign row   = opc[5:3];
    assign col   = opc[2:0];
    assign pcode = opc[5:4];
    assign qbit  = opc[3];
endmodule

// File: rtl/opdec_main_page.sv
module opdec_main_page
    import opdec_pkg::*;
(
    input  logic [1:0] grp,
    input  logic [2:0] row,
    input  logic [2:0] col,
    input  logic [1:0] pcode,
    input  logic       qbit,
    output main_dec_t  dec
);
    always_comb begin
        dec        = '0;
        dec.f.cls  = OP_NOP;
        dec.kind   = IMM_NONE;
        dec.f.dst  = row;
        dec.f.src  = col;
        dec.f.pair = pcode;
        dec.f.cond = row;
        dec.f.func = row;
        unique case (grp)
            2'd0: begin
                unique case (col)
                    3'd0: begin
                        if (row == 3'd0) begin
                            dec.f.cls = OP_NOP;
                        end else if (row == 3'd1) begin
                            dec.f.cls = OP_SWAP_AF;
                        end else begin
                            dec.kind = IMM_S8;
                            if (row == 3'd2) begin
                                dec.f.cls = OP_DEC_JNZ;
                            end else if (row == 3'd3) begin
                                dec.f.cls = OP_JREL;
                            end else begin
                                dec.f.cls  = OP_JREL_CC;
                                dec.f.cond = {1'b0, row[1:0]};
                            end
                        end
                    end
                    3'd1: begin
                        if (!qbit) begin
                            dec.f.cls = OP_LD_PAIR_I;
                            dec.kind  = IMM_W16;
                        end else begin
                            dec.f.cls = OP_ADD_HL;
                        end
                    end
                    3'd2: begin
                        if (!row[2]) begin
                            dec.f.cls = qbit ? OP_LD_A_PAIR : OP_ST_A_PAIR;
                        end else begin
                            dec.kind = IMM_W16;
                            unique case (row[1:0])
                                2'd0: dec.f.cls = OP_ST_HL_ABS;
                                2'd1: dec.f.cls = OP_LD_HL_ABS;
                                2'd2: dec.f.cls = OP_ST_A_ABS;
                                default: dec.f.cls = OP_LD_A_ABS;
                            endcase
                        end
                    end
                    3'd3: dec.f.cls = qbit ? OP_DEC_PAIR : OP_INC_PAIR;
                    3'd4: dec.f.cls = OP_INC_REG;
                    3'd5: dec.f.cls = OP_DEC_REG;
                    3'd6: begin
                        dec.f.cls = OP_LD_REG_I;
                        dec.kind  = IMM_U8;
                    end
                    default: dec.f.cls = OP_ACC_OP;
                endcase
            end
            2'd1: begin
                if (row == 3'd6 && col == 3'd6) begin
                    dec.f.cls = OP_HALT;
                end else begin
                    dec.f.cls = OP_LD_REG;
                end
            end
            2'd2: dec.f.cls = OP_ALU_REG;
            default: begin
                unique case (col)
                    3'd0: dec.f.cls = OP_RET_CC;
                    3'd1: begin
                        if (!qbit) begin
                            dec.f.cls = OP_POP;
                        end else begin
                            unique case (pcode)
                                2'd0: dec.f.cls = OP_RET;
                                2'd1: dec.f.cls = OP_SWAP_BANK;
                                2'd2: dec.f.cls = OP_JP_HL;
                                default: dec.f.cls = OP_LD_SP_HL;
                            endcase
                        end
                    end
                    3'd2: begin
                        dec.f.cls = OP_JP_CC;
                        dec.kind  = IMM_W16;
                    end
                    3'd3: begin
                        unique case (row)
                            3'd0: begin
                                dec.f.cls = OP_JP;
                                dec.kind  = IMM_W16;
                            end
                            3'd1: dec.cb_prefix = 1'b1;
                            3'd2: begin
                                dec.f.cls = OP_PORT_OUT;
                                dec.kind  = IMM_U8;
                            end
                            3'd3: begin
                                dec.f.cls = OP_PORT_IN;
                                dec.kind  = IMM_U8;
                            end
                            3'd4: dec.f.cls = OP_SWAP_SPHL;
                            3'd5: dec.f.cls = OP_SWAP_DEHL;
                            3'd6: dec.f.cls = OP_INT_OFF;
                            default: dec.f.cls = OP_INT_ON;
                        endcase
                    end
                    3'd4: begin
                        dec.f.cls = OP_CALL_CC;
                        dec.kind  = IMM_W16;
                    end
                    3'd5: begin
                        if (!qbit) begin
                            dec.f.cls = OP_PUSH;
                        end else if (pcode == 2'd0) begin
                            dec.f.cls = OP_CALL;
                            dec.kind  = IMM_W16;
                        end else begin
                            dec.f         = '0;
                            dec.f.cls     = OP_UNSUP;
                            dec.f.unsup   = 1'b1;
                        end
                    end
                    3'd6: begin
                        dec.f.cls = OP_ALU_IMM;
                        dec.kind  = IMM_U8;
                    end
                    default: begin
                        dec.f.cls = OP_RESTART;
                        dec.f.imm = {{(IMM_W-6){1'b0}}, row, 3'b000};
                    end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/opdec_bit_page.sv
module opdec_bit_page
    import opdec_pkg::*;
(
    input  logic [1:0]  grp,
    input  logic [2:0]  row,
    input  logic [2:0]  col,
    output dec_fields_t f
);
    always_comb begin
        f         = '0;
        f.src     = col;
        f.dst     = col;
        unique case (grp)
            2'd0: begin
                f.cls  = OP_SHIFT;
                f.func = row;
            end
            2'd1: begin
                f.cls     = OP_BIT_TEST;
                f.bit_idx = row;
            end
            2'd2: begin
                f.cls     = OP_BIT_CLR;
                f.bit_idx = row;
            end
            default: begin
                f.cls     = OP_BIT_SET;
                f.bit_idx = row;
            end
        endcase
    end
endmodule

// File: rtl/opdec_stream.sv
module opdec_stream
    import opdec_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CLS_W-1:0]  out_class,
    output logic [2:0]        out_dst,
    output logic [2:0]        out_src,
    output logic [1:0]        out_pair,
    output logic [2:0]        out_cond,
    output logic [2:0]        out_func,
    output logic [2:0]        out_bit,
    output logic [IMM_W-1:0]  out_imm,
    output logic [LEN_W-1:0]  out_len,
    output logic [ADDR_W-1:0] out_start,
    output logic              out_unsup
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        fsm_e              fsm;
        dec_fields_t       wrk;
        logic              wrk_sx;
        logic [LEN_W-1:0]  wrk_len;
        logic [ADDR_W-1:0] wrk_start;
        logic              ov;
        dec_fields_t       orec;
        logic [LEN_W-1:0]  olen;
        logic [ADDR_W-1:0] ostart;
    } state_t;

    state_t st_d, st_q;

    logic [1:0] grp;
    logic [2:0] row, col;
    logic [1:0] pcode;
    logic       qbit;
    main_dec_t   mdec;
    dec_fields_t bdec;

    opdec_split u_split (
        .opc   (in_byte),
        .grp   (grp),
        .row   (row),
        .col   (col),
        .pcode (pcode),
        .qbit  (qbit)
    );

    opdec_main_page u_main (
        .grp   (grp),
        .row   (row),
        .col   (col),
        .pcode (pcode),
        .qbit  (qbit),
        .dec   (mdec)
    );

    opdec_bit_page u_bits (
        .grp (grp),
        .row (row),
        .col (col),
        .f   (bdec)
    );

    logic              rdy;
    logic              take;
    logic              fin;
    dec_fields_t       fin_rec;
    logic [LEN_W-1:0]  fin_len;
    logic [ADDR_W-1:0] fin_start;

    always_comb begin
        st_d      = st_q;
        rdy       = !st_q.ov || out_ready;
        take      = in_valid && rdy;
        fin       = 1'b0;
        fin_rec   = st_q.wrk;
        fin_len   = st_q.wrk_len + LEN_ONE;
        fin_start = st_q.wrk_start;

        if (st_q.ov && out_ready) begin
            st_d.ov = 1'b0;
        end

        if (take) begin
            unique case (st_q.fsm)
                ST_OPC: begin
                    st_d.wrk       = mdec.f;
                    st_d.wrk_start = in_addr;
                    st_d.wrk_len   = LEN_ONE;
                    st_d.wrk_sx    = 1'b0;
                    fin_rec        = mdec.f;
                    fin_start      = in_addr;
                    fin_len        = LEN_ONE;
                    if (mdec.f.unsup) begin
                        fin = 1'b1;
                    end else if (mdec.cb_prefix) begin
                        st_d.fsm = ST_CBOP;
                    end else begin
                        unique case (mdec.kind)
                            IMM_NONE: fin = 1'b1;
                            IMM_U8:   st_d.fsm = ST_IMM8;
                            IMM_S8: begin
                                st_d.wrk_sx = 1'b1;
                                st_d.fsm    = ST_IMM8;
                            end
                            default:  st_d.fsm = ST_IMM_LO;
                        endcase
                    end
                end
                ST_CBOP: begin
                    fin      = 1'b1;
                    fin_rec  = bdec;
                    st_d.fsm = ST_OPC;
                end
                ST_IMM8: begin
                    fin         = 1'b1;
                    fin_rec.imm = st_q.wrk_sx ? {{(IMM_W-8){in_byte[7]}}, in_byte}
                                              : {{(IMM_W-8){1'b0}}, in_byte};
                    st_d.fsm    = ST_OPC;
                end
                ST_IMM_LO: begin
                    st_d.wrk.imm[7:0] = in_byte;
                    st_d.wrk_len      = st_q.wrk_len + LEN_ONE;
                    st_d.fsm          = ST_IMM_HI;
                end
                default: begin
                    fin         = 1'b1;
                    fin_rec.imm = {in_byte, st_q.wrk.imm[7:0]};
                    st_d.fsm    = ST_OPC;
                end
            endcase
        end

        if (fin) begin
            st_d.ov     = 1'b1;
            st_d.orec   = fin_rec;
            st_d.olen   = fin_len;
            st_d.ostart = fin_start;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = rdy;
    assign out_valid = st_q.ov;
    assign out_class = st_q.orec.cls;
    assign out_dst   = st_q.orec.dst;
    assign out_src   = st_q.orec.src;
    assign out_pair  = st_q.orec.pair;
    assign out_cond  = st_q.orec.cond;
    assign out_func  = st_q.orec.func;
    assign out_bit   = st_q.orec.bit_idx;
    assign out_imm   = st_q.orec.imm;
    assign out_len   = st_q.olen;
    assign out_start = st_q.ostart;
    assign out_unsup = st_q.orec.unsup;

endmodule

// File: rtl/opdec_stream_chk.sv
module opdec_stream_chk
    import opdec_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CLS_W-1:0]  out_class,
    input logic [IMM_W-1:0]  out_imm,
    input logic [LEN_W-1:0]  out_len,
    input logic [ADDR_W-1:0] out_start,
    input logic              out_unsup
);
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(3))) else $error("length out of range"); // R3

    AST_UNSUP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_unsup) |-> (out_len == LEN_W'(1) && out_imm == '0)) else $error("unsupported record shape"); // R10

    AST_BITPAGE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_class == OP_SHIFT || out_class == OP_BIT_TEST ||
                       out_class == OP_BIT_CLR || out_class == OP_BIT_SET))
        |-> out_len == LEN_W'(2)) else $error("bit page length"); // R7

    AST_RESTART_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == OP_RESTART) |-> (out_imm[2:0] == 3'd0 && out_imm[IMM_W-1:6] == '0))
        else $error("restart target"); // R6

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready) else $error("byte taken while stalled"); // R12

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_class) && $stable(out_imm) &&
                                       $stable(out_len) && $stable(out_start)))
        else $error("record changed while stalled"); // R12
endmodule

bind opdec_stream opdec_stream_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_class (out_class),
    .out_imm   (out_imm),
    .out_len   (out_len),
    .out_start (out_start),
    .out_unsup (out_unsup)
);

// File: tb/test_opdec_stream.sv
module test_opdec_stream;
    import opdec_pkg::*;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned LEN_W  = 3;

    localparam logic [2:0] KN = 3'd0, KD = 3'd1, KS = 3'd2, KP = 3'd3,
                           KC = 3'd4, KF = 3'd5, KB = 3'd6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_byte = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic              in_ready;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [CLS_W-1:0]  out_class;
    logic [2:0]        out_dst, out_src, out_cond, out_func, out_bit;
    logic [1:0]        out_pair;
    logic [IMM_W-1:0]  out_imm;
    logic [LEN_W-1:0]  out_len;
    logic [ADDR_W-1:0] out_start;
    logic              out_unsup;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    opdec_stream #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_opdec_stream (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_addr(in_addr), .in_ready(in_ready), .out_valid(out_valid),
        .out_ready(out_ready), .out_class(out_class), .out_dst(out_dst),
        .out_src(out_src), .out_pair(out_pair), .out_cond(out_cond),
        .out_func(out_func), .out_bit(out_bit), .out_imm(out_imm),
        .out_len(out_len), .out_start(out_start), .out_unsup(out_unsup)
    );

    typedef struct packed {
        logic [1:0]       n;
        logic [7:0]       b0;
        logic [7:0]       b1;
        logic [7:0]       b2;
        logic [CLS_W-1:0] cls;
        logic [2:0]       len;
        logic [15:0]      imm;
        logic [2:0]       k1s;
        logic [2:0]       k1v;
        logic [2:0]       k2s;
        logic [2:0]       k2v;
        logic             uns;
        logic [3:0]       req;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'h00, 8'h00, 8'h00, OP_NOP,       3'd1, 16'h0000, KN, 3'd0, KN, 3'd0, 1'b0, 4'd1},  // R1
        '{2'd1, 8'h41, 8'h00, 8'h00, OP_LD_REG,    3'd1, 16'h0000, KD, 3'd0, KS, 3'd1, 1'b0, 4'd1},  // R1
        '{2'd1, 8'h7E, 8'h00, 8'h00, OP_LD_REG,    3'd1, 16'h0000, KD, 3'd7, KS, 3'd6, 1'b0, 4'd1},  // R1
        '{2'd1, 8'h76, 8'h00, 8'h00, OP_HALT,      3'd1, 16'h0000, KN, 3'd0, KN, 3'd0, 1'b0, 4'd1},  // R1
        '{2'd2, 8'h10, 8'hFE, 8'h00, OP_DEC_JNZ,   3'd2, 16'hFFFE, KN, 3'd0, KN, 3'd0, 1'b0, 4'd2},  // R2
        '{2'd2, 8'h38, 8'h05, 8'h00, OP_JREL_CC,   3'd2, 16'h0005, KC, 3'd3, KN, 3'd0, 1'b0, 4'd2},  // R2
        '{2'd2, 8'h18, 8'h80, 8'h00, OP_JREL,      3'd2, 16'hFF80, KN, 3'd0, KN, 3'd0, 1'b0, 4'd2},  // R2
        '{2'd2, 8'h20, 8'h7F, 8'h00, OP_JREL_CC,   3'd2, 16'h007F, KC, 3'd0, KN, 3'd0, 1'b0, 4'd2},  // R2
        '{2'd3, 8'h21, 8'h34, 8'h12, OP_LD_PAIR_I, 3'd3, 16'h1234, KP, 3'd2, KN, 3'd0, 1'b0, 4'd3},  // R3
        '{2'd3, 8'h32, 8'hCD, 8'hAB, OP_ST_A_ABS,  3'd3, 16'hABCD, KN, 3'd0, KN, 3'd0, 1'b0, 4'd3},  // R3
        '{2'd3, 8'h2A, 8'h00, 8'hC0, OP_LD_HL_ABS, 3'd3, 16'hC000, KN, 3'd0, KN, 3'd0, 1'b0, 4'd3},  // R3
        '{2'd1, 8'h9A, 8'h00, 8'h00, OP_ALU_REG,   3'd1, 16'h0000, KF, 3'd3, KS, 3'd2, 1'b0, 4'd4},  // R4
        '{2'd2, 8'hFE, 8'h7F, 8'h00, OP_ALU_IMM,   3'd2, 16'h007F, KF, 3'd7, KN, 3'd0, 1'b0, 4'd4},  // R4
        '{2'd2, 8'hC6, 8'h80, 8'h00, OP_ALU_IMM,   3'd2, 16'h0080, KF, 3'd0, KN, 3'd0, 1'b0, 4'd4},  // R4
        '{2'd1, 8'hE8, 8'h00, 8'h00, OP_RET_CC,    3'd1, 16'h0000, KC, 3'd5, KN, 3'd0, 1'b0, 4'd5},  // R5
        '{2'd3, 8'hFA, 8'h00, 8'h80, OP_JP_CC,     3'd3, 16'h8000, KC, 3'd7, KN, 3'd0, 1'b0, 4'd5},  // R5
        '{2'd3, 8'hC4, 8'h11, 8'h22, OP_CALL_CC,   3'd3, 16'h2211, KC, 3'd0, KN, 3'd0, 1'b0, 4'd5},  // R5
        '{2'd1, 8'hFF, 8'h00, 8'h00, OP_RESTART,   3'd1, 16'h0038, KN, 3'd0, KN, 3'd0, 1'b0, 4'd6},  // R6
        '{2'd1, 8'hC7, 8'h00, 8'h00, OP_RESTART,   3'd1, 16'h0000, KN, 3'd0, KN, 3'd0, 1'b0, 4'd6},  // R6
        '{2'd1, 8'hEF, 8'h00, 8'h00, OP_RESTART,   3'd1, 16'h0028, KN, 3'd0, KN, 3'd0, 1'b0, 4'd6},  // R6
        '{2'd2, 8'hCB, 8'h7A, 8'h00, OP_BIT_TEST,  3'd2, 16'h0000, KB, 3'd7, KS, 3'd2, 1'b0, 4'd7},  // R7
        '{2'd2, 8'hCB, 8'h0E, 8'h00, OP_SHIFT,     3'd2, 16'h0000, KF, 3'd1, KS, 3'd6, 1'b0, 4'd7},  // R7
        '{2'd2, 8'hCB, 8'hC7, 8'h00, OP_BIT_SET,   3'd2, 16'h0000, KB, 3'd0, KS, 3'd7, 1'b0, 4'd7},  // R7
        '{2'd2, 8'hCB, 8'h9D, 8'h00, OP_BIT_CLR,   3'd2, 16'h0000, KB, 3'd3, KS, 3'd5, 1'b0, 4'd7},  // R7
        '{2'd2, 8'hD3, 8'h42, 8'h00, OP_PORT_OUT,  3'd2, 16'h0042, KN, 3'd0, KN, 3'd0, 1'b0, 4'd8},  // R8
        '{2'd2, 8'hDB, 8'h10, 8'h00, OP_PORT_IN,   3'd2, 16'h0010, KN, 3'd0, KN, 3'd0, 1'b0, 4'd8},  // R8
        '{2'd1, 8'hEB, 8'h00, 8'h00, OP_SWAP_DEHL, 3'd1, 16'h0000, KN, 3'd0, KN, 3'd0, 1'b0, 4'd8},  // R8
        '{2'd1, 8'hF3, 8'h00, 8'h00, OP_INT_OFF,   3'd1, 16'h0000, KN, 3'd0, KN, 3'd0, 1'b0, 4'd8},  // R8
        '{2'd3, 8'hC3, 8'hEF, 8'hBE, OP_JP,        3'd3, 16'hBEEF, KN, 3'd0, KN, 3'd0, 1'b0, 4'd8},  // R8
        '{2'd1, 8'hF5, 8'h00, 8'h00, OP_PUSH,      3'd1, 16'h0000, KP, 3'd3, KN, 3'd0, 1'b0, 4'd9},  // R9
        '{2'd1, 8'hC1, 8'h00, 8'h00, OP_POP,       3'd1, 16'h0000, KP, 3'd0, KN, 3'd0, 1'b0, 4'd9},  // R9
        '{2'd1, 8'h0B, 8'h00, 8'h00, OP_DEC_PAIR,  3'd1, 16'h0000, KP, 3'd0, KN, 3'd0, 1'b0, 4'd9},  // R9
        '{2'd1, 8'h1A, 8'h00, 8'h00, OP_LD_A_PAIR, 3'd1, 16'h0000, KP, 3'd1, KN, 3'd0, 1'b0, 4'd9},  // R9
        '{2'd1, 8'hDD, 8'h00, 8'h00, OP_UNSUP,     3'd1, 16'h0000, KN, 3'd0, KN, 3'd0, 1'b1, 4'd10}, // R10
        '{2'd1, 8'hED, 8'h00, 8'h00, OP_UNSUP,     3'd1, 16'h0000, KN, 3'd0, KN, 3'd0, 1'b1, 4'd10}, // R10
        '{2'd1, 8'hFD, 8'h00, 8'h00, OP_UNSUP,     3'd1, 16'h0000, KN, 3'd0, KN, 3'd0, 1'b1, 4'd10}, // R10
        '{2'd2, 8'h36, 8'h99, 8'h00, OP_LD_REG_I,  3'd2, 16'h0099, KD, 3'd6, KN, 3'd0, 1'b0, 4'd1},  // R1
        '{2'd1, 8'h08, 8'h00, 8'h00, OP_SWAP_AF,   3'd1, 16'h0000, KN, 3'd0, KN, 3'd0, 1'b0, 4'd1}   // R1
    };

    function automatic logic [2:0] key_val(input logic [2:0] sel);
        case (sel)
            KD:      return out_dst;
            KS:      return out_src;
            KP:      return {1'b0, out_pair};
            KC:      return out_cond;
            KF:      return out_func;
            KB:      return out_bit;
            default: return 3'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [ADDR_W-1:0] a);
        in_valid = 1'b1;
        in_byte  = b;
        in_addr  = a;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] addr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R13 reset out_valid", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R13 reset in_ready", 32'(in_ready), 32'd1);

        // Table walk; start address chain crosses 0xFFFF -> 0x0000 (R11)
        addr = 16'hFFE0;
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            bit ok;
            v = VECS[i];
            send_byte(v.b0, addr);
            if (v.n > 2'd1) send_byte(v.b1, addr + 16'd1);
            if (v.n > 2'd2) send_byte(v.b2, addr + 16'd2);
            ok = out_valid && out_class == v.cls && out_len == v.len &&
                 out_imm == v.imm && out_unsup == v.uns && out_start == addr &&
                 key_val(v.k1s) == v.k1v && key_val(v.k2s) == v.k2v;
            chk(ok, $sformatf("R%0d/R11 vector %0d byte %h", v.req, i, v.b0),
                {out_class, 2'b0, out_len, out_imm[7:0], out_start[7:0], 3'b0, out_unsup},
                {v.cls, 2'b0, v.len, v.imm[7:0], addr[7:0], 3'b0, v.uns});
            if (!ok) $display("  detail: imm=%h/%h keys=%0d,%0d/%0d,%0d", out_imm, v.imm,
                              key_val(v.k1s), key_val(v.k2s), v.k1v, v.k2v);
            addr = addr + ADDR_W'(v.n);
        end

        // R3: gaps between bytes of a 16-bit immediate
        send_byte(8'h21, 16'h0300);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R3 no early record", 32'(out_valid), 32'd0);
        send_byte(8'h78, 16'h0301);
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R3 no record before high byte", 32'(out_valid), 32'd0);
        send_byte(8'h56, 16'h0302);
        chk(out_valid && out_imm == 16'h5678 && out_len == 3'd3 && out_start == 16'h0300,
            "R3 gapped immediate", {out_imm, 13'd0, out_len}, {16'h5678, 13'd0, 3'd3});
        @(negedge clk);

        // R12: back-pressure holds record and blocks input
        out_ready = 1'b0;
        send_byte(8'h00, 16'h0200);
        in_valid = 1'b1;
        in_byte  = 8'h76;
        in_addr  = 16'h0201;
        for (int k = 0; k < 3; k++) begin
            chk(in_ready == 1'b0, "R12 in_ready low while stalled", 32'(in_ready), 32'd0);
            chk(out_valid && out_class == CLS_W'(OP_NOP) && out_start == 16'h0200,
                "R12 record held", {out_class, out_start}, {CLS_W'(OP_NOP), 16'h0200});
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_class == CLS_W'(OP_HALT) && out_start == 16'h0201,
            "R12 byte taken after release", {out_class, out_start}, {CLS_W'(OP_HALT), 16'h0201});
        @(negedge clk);
        chk(out_valid == 1'b0, "R12 record consumed", 32'(out_valid), 32'd0);

        // R13: reset drops a partial instruction
        send_byte(8'hC3, 16'h0400);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        send_byte(8'h00, 16'h0500);
        chk(out_valid && out_class == CLS_W'(OP_NOP) && out_len == 3'd1 && out_start == 16'h0500,
            "R13 fresh decode after reset", {out_class, out_len}, {CLS_W'(OP_NOP), 3'd1});

        summary();
        $finish;
    end
endmodule